// File: doc/BRIEF.md
# Periodic Up-Counting Timer with Prescaler and Event Interrupts

This block is a timer for periodic interrupts. A counter advances on ticks taken from one of two source-pulse inputs. Each tick is first passed through a divider that divides by 1, 2, 4 or 8. In up mode the counter climbs from zero to a limit set by software. It then returns to zero, so one period is limit+1 ticks.

Two events are recorded in sticky flags. The first is reaching the limit and the second is returning to zero. Each flag can drive the single interrupt request through its own enable bit. Software configures the block through a small synchronous register port. A clear command restarts the counter and the divider together. Flags are cleared by a write-one to the flag register or by a per-flag acknowledge input.

A typical use is a heartbeat, for example a limit of 49999 with divide-by-8, so that the interrupt service toggles an output once per period.

Top module: `uptimer_top`

## Requirements
- R1: After reset the count reads 0, both flags read 0, `irq` is low and the control register reads 0, which means the timer is stopped.
- R2: Control bits [3:2] set the divider: 00 advances the counter once per selected source pulse, 01 once per 2, 10 once per 4 and 11 once per 8.
- R3: In up mode the count goes 0,1,…,limit and then returns to 0, so one period is limit+1 divided ticks. The limit is held at address 1.
- R4: The compare flag, bit 0 of the flag register at address 3, is set by the tick that moves the count onto the limit.
- R5: The wrap flag, bit 1 of the flag register, is set by the tick that moves the count from the limit back to 0.
- R6: `irq` is high exactly when an enabled flag is set. Control bit 7 enables the compare flag and control bit 6 enables the wrap flag.
- R7: Writing a 1 to a flag bit clears that flag and writing a 0 leaves it unchanged. A one-cycle pulse on `ack[i]` clears flag i.
- R8: Writing control bit 5 as 1 sets the count and the divider state to zero in that cycle. Bit 5 always reads back 0.
- R9: Control bits [1:0] set the mode. 01 is up mode. Any other value holds both the count and the divider.
- R10: Control bit 4 selects `src_tick[1]` when it is 1 and `src_tick[0]` when it is 0. Pulses on the unselected input have no effect.
- R11: The count can be read at address 2. Writes to that address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 2 | Source count-enable pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 limit, 2 count, 3 flags |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr` (combinational) |
| ack | input | 2 | Per-flag acknowledge pulses (bit 0 compare, bit 1 wrap) |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the divider and limit settings at tick counts that stop one short of the limit, exactly on it and one past it. A design that sets the compare flag a tick late, or wraps at limit rather than limit+1, fails those points. A limit of zero is tested because a design that never sees the count "move onto" the limit would miss the compare flag there. A clear issued with the divider partly filled exposes a design that clears only the counter, because it would then tick early. The bench also drives pulses in stop and reserved modes, on the unselected source, and on write-zero flag writes, and checks at the ports that none of them changes the observable state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PS_W = 3;          // divider state width, enough for /8
    localparam int NFLAG = 2;         // compare and wrap

    localparam int FL_CMP = 0;
    localparam int FL_WRAP = 1;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_LIMIT = 2'd1,
        A_COUNT = 2'd2,
        A_FLAGS = 2'd3
    } tmr_addr_e;

    typedef enum logic [1:0] {
        M_HOLD = 2'd0,
        M_UP   = 2'd1,
        M_RSV2 = 2'd2,
        M_RSV3 = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      cmp_ie;
        logic      wrap_ie;
        logic      src_sel;
        logic [1:0] div;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    // last divider state before a tick for a given ratio code
    function automatic logic [PS_W-1:0] div_last(input logic [1:0] code);
        logic [PS_W-1:0] r;
        r = '0;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(code)) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] src,
    input  logic       sel,
    input  logic [1:0] div,
    output logic       tick
);
    logic [PS_W-1:0] ps_q;
    logic            pulse;

    always_comb begin
        pulse = run && src[sel];
        tick  = pulse && (ps_q == div_last(div));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ps_q <= '0;
        end else if (pulse) begin
            ps_q <= tick ? '0 : ps_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] cnt,
    output logic          reach,
    output logic          wrap
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] nxt;
    logic          at_end;

    always_comb begin
        at_end = (cnt_q >= limit);
        nxt    = at_end ? '0 : cnt_q + 1'b1;
        wrap   = tick && !clr && at_end;
        reach  = tick && !clr && (nxt == limit);
        cnt    = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= nxt;
        end
    end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    logic [NF-1:0] req;

    for (genvar g = 0; g < NF; g++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)         f_q <= 1'b0;
            else if (set[g]) f_q <= 1'b1;      // a new event wins over a clear
            else if (clr[g]) f_q <= 1'b0;
        end
        assign flags[g] = f_q;
        assign req[g]   = f_q && en[g];
    end

    assign irq = |req;
endmodule

// File: rtl/uptimer_top.sv
module uptimer_top
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    src_tick,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    input  logic [1:0]    ack,
    output logic          irq
);
    tmr_ctrl_t     ctrl_q;
    logic [CW-1:0] limit_q;
    logic [CW-1:0] cnt_q;
    logic          run;
    logic          clr_pulse;
    logic          tick;
    logic          reach;
    logic          wrap;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] flag_en;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    tmr_addr_e     a;

    always_comb begin
        a         = tmr_addr_e'(addr);
        run       = (ctrl_q.mode == M_UP);
        clr_pulse = wr_en && (a == A_CTRL) && wdata[5];
        flag_en   = {ctrl_q.wrap_ie, ctrl_q.cmp_ie};
        flag_set  = {wrap, reach};
        flag_clr  = ack | ((wr_en && (a == A_FLAGS)) ? wdata[NFLAG-1:0] : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{cmp_ie: 1'b0, wrap_ie: 1'b0, src_sel: 1'b0, div: 2'd0, mode: M_HOLD};
            limit_q <= '0;
        end else if (wr_en) begin
            if (a == A_CTRL) begin
                ctrl_q.cmp_ie  <= wdata[7];
                ctrl_q.wrap_ie <= wdata[6];
                ctrl_q.src_sel <= wdata[4];
                ctrl_q.div     <= wdata[3:2];
                ctrl_q.mode    <= tmr_mode_e'(wdata[1:0]);
            end else if (a == A_LIMIT) begin
                limit_q <= wdata;
            end
        end
    end

    tmr_prescaler u_ps (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_pulse),
        .run  (run),
        .src  (src_tick),
        .sel  (ctrl_q.src_sel),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_pulse),
        .tick  (tick),
        .limit (limit_q),
        .cnt   (cnt_q),
        .reach (reach),
        .wrap  (wrap)
    );

    tmr_flags #(.NF(NFLAG)) u_flg (
        .clk   (clk),
        .rst   (rst),
        .set   (flag_set),
        .clr   (flag_clr),
        .en    (flag_en),
        .flags (flags_q),
        .irq   (irq)
    );

    always_comb begin
        rdata = '0;
        case (a)
            A_CTRL:  rdata[7:0] = {ctrl_q.cmp_ie, ctrl_q.wrap_ie, 1'b0, ctrl_q.src_sel,
                                   ctrl_q.div, ctrl_q.mode};
            A_LIMIT: rdata = limit_q;
            A_COUNT: rdata = cnt_q;
            A_FLAGS: rdata[NFLAG-1:0] = flags_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/uptimer_chk.sv
module uptimer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          clr,
    input logic          run,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] limit,
    input logic [1:0]    flags,
    input logic [1:0]    en,
    input logic          irq
);
    // R3: a tick below the limit advances the count by one
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && cnt < limit) |=> (cnt == $past(cnt) + 1'b1));

    // R4: moving onto the limit raises the compare flag
    a_r4_cmp_set: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && cnt < limit && (cnt + 1'b1) == limit) |=> flags[0]);

    // R5: a tick at the limit returns to zero and raises the wrap flag
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && cnt == limit) |=> (cnt == '0 && flags[1]));

    // R6: with both enables off no request is raised
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        (en == 2'b00) |-> !irq);

    // R8: a clear command zeroes the count
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R9: outside up mode the count holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cnt));
endmodule

bind uptimer_top uptimer_chk #(.CW(CW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .clr   (clr_pulse),
    .run   (run),
    .cnt   (cnt_q),
    .limit (limit_q),
    .flags (flags_q),
    .en    (flag_en),
    .irq   (irq)
);

// File: tb/uptimer_top_tb_top.sv
module uptimer_top_tb_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    src_tick = 2'b00;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic [1:0]    ack = 2'b00;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    uptimer_top #(.CW(CW)) dut_i (
        .clk(clk), .rst(rst), .src_tick(src_tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  div;
        logic [15:0] lim;
        logic [15:0] steps;
        logic [15:0] cnt;
        logic        cmp;
        logic        wrp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd5,   16'd3,  16'd3,  1'b0, 1'b0},
        '{2'd0, 16'd5,   16'd5,  16'd5,  1'b1, 1'b0},
        '{2'd0, 16'd5,   16'd6,  16'd0,  1'b1, 1'b1},
        '{2'd1, 16'd4,   16'd9,  16'd4,  1'b1, 1'b0},
        '{2'd2, 16'd3,   16'd20, 16'd1,  1'b1, 1'b1},
        '{2'd3, 16'd10,  16'd87, 16'd10, 1'b1, 1'b0},
        '{2'd3, 16'd100, 16'd79, 16'd9,  1'b0, 1'b0},
        '{2'd0, 16'd0,   16'd4,  16'd0,  1'b1, 1'b1},
        '{2'd1, 16'd2,   16'd1,  16'd0,  1'b0, 1'b0}
    };

    function automatic logic [CW-1:0] mk_ctrl(input logic [1:0] mode, input logic [1:0] div,
                                              input logic sel, input logic clr,
                                              input logic wie, input logic cie);
        logic [CW-1:0] v;
        v = '0;
        v[7:0] = {cie, wie, clr, sel, div, mode};
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [CW-1:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [1:0] m, input int n);
        if (n > 0) begin
            @(negedge clk);
            src_tick = m;
            repeat (n) @(posedge clk);
            @(negedge clk);
            src_tick = 2'b00;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [CW-1:0] v;
        logic [CW-1:0] held;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(2'd2, v); check("R1 count", v, 0);
        bus_rd(2'd3, v); check("R1 flags", v, 0);
        bus_rd(2'd0, v); check("R1 ctrl", v, 0);
        check("R1 irq", irq, 0);

        // table sweep: R2 divider, R3 wrap, R4/R5 flags
        for (int i = 0; i < NV; i++) begin
            bus_wr(2'd1, VECS[i].lim);
            bus_wr(2'd0, mk_ctrl(2'b01, VECS[i].div, 1'b0, 1'b1, 1'b0, 1'b0));
            bus_wr(2'd3, 16'h0003);
            pulse(2'b01, int'(VECS[i].steps));
            bus_rd(2'd2, v); check("R2/R3 vector count", v, VECS[i].cnt);
            bus_rd(2'd3, v);
            check("R4 vector compare flag", v[0], VECS[i].cmp);
            check("R5 vector wrap flag", v[1], VECS[i].wrp);
        end

        // R6 / R7 interrupt and flag clearing
        bus_wr(2'd1, 16'd3);
        bus_wr(2'd0, mk_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1));
        bus_wr(2'd3, 16'h0003);
        pulse(2'b01, 3);
        bus_rd(2'd3, v); check("R4 flags at limit", v, 1);
        check("R6 irq on enabled compare", irq, 1);
        pulse(2'b01, 1);
        bus_rd(2'd3, v); check("R5 flags after wrap", v, 3);
        bus_wr(2'd3, 16'h0000);
        bus_rd(2'd3, v); check("R7 write zero keeps flags", v, 3);
        bus_wr(2'd3, 16'h0001);
        bus_rd(2'd3, v); check("R7 write one clears compare", v, 2);
        check("R6 irq low with wrap not enabled", irq, 0);
        @(negedge clk); ack = 2'b10;
        @(negedge clk); ack = 2'b00;
        bus_rd(2'd3, v); check("R7 ack clears wrap", v, 0);
        bus_wr(2'd0, mk_ctrl(2'b01, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        pulse(2'b01, 4);
        bus_rd(2'd3, v); check("R5 wrap after full period", v, 3);
        check("R6 irq on enabled wrap", irq, 1);

        // R9 hold outside up mode
        bus_wr(2'd3, 16'h0003);
        pulse(2'b01, 2);
        bus_rd(2'd2, held); check("R3 count before hold", held, 2);
        bus_wr(2'd0, mk_ctrl(2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        pulse(2'b01, 10);
        bus_rd(2'd2, v); check("R9 mode 00 holds", v, held);
        bus_wr(2'd0, mk_ctrl(2'b10, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        pulse(2'b01, 5);
        bus_rd(2'd2, v); check("R9 mode 10 holds", v, held);
        bus_rd(2'd3, v); check("R9 no flags while held", v, 0);

        // R10 source select
        bus_wr(2'd1, 16'd100);
        bus_wr(2'd0, mk_ctrl(2'b01, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
        pulse(2'b01, 5);
        bus_rd(2'd2, v); check("R10 unselected source ignored", v, 0);
        pulse(2'b10, 4);
        bus_rd(2'd2, v); check("R10 selected source counts", v, 4);

        // R8 clear resets divider too
        bus_wr(2'd0, mk_ctrl(2'b01, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0));
        pulse(2'b01, 5);
        bus_wr(2'd0, mk_ctrl(2'b01, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0));
        bus_rd(2'd0, v); check("R8 clear bit reads zero", v, 16'h000D);
        bus_rd(2'd2, v); check("R8 count zero after clear", v, 0);
        pulse(2'b01, 8);
        bus_rd(2'd2, v); check("R8 divider restarted", v, 1);

        // R11 count is read-only
        bus_wr(2'd2, 16'h0055);
        bus_rd(2'd2, v); check("R11 count write ignored", v, 1);

        // R3 long period: limit 999 at /8
        bus_wr(2'd1, 16'd999);
        bus_wr(2'd0, mk_ctrl(2'b01, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0));
        bus_wr(2'd3, 16'h0003);
        pulse(2'b01, 7999);
        bus_rd(2'd2, v); check("R3 count at end of period", v, 999);
        bus_rd(2'd3, v); check("R5 no wrap before period end", v[1], 0);
        pulse(2'b01, 1);
        bus_rd(2'd2, v); check("R3 count after period", v, 0);
        bus_rd(2'd3, v); check("R5 wrap at period end", v[1], 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule